// File: doc/BRIEF.md
# Interleaved Banked Byte Memory

This block is a 32K-byte memory assembled from sixteen independent banks of 2K bytes. Each byte has its own address. A single static mode input selects how the 15-bit address is divided between a bank number and an offset inside that bank. In high-order mode the most significant address bits choose the bank, so each bank holds one contiguous 2K region. In low-order mode the least significant bits choose the bank, so consecutive bytes fall in different banks.

Requesters issue one access per cycle on a simple valid-qualified interface. An access is a byte, a 16-bit halfword or a 32-bit word, and multi-byte values are little-endian. Every accepted request gets a response in the following cycle. That response carries the read data, or an error flag when the access is not naturally aligned. Memory contents after reset are undefined. Stored bytes stay in their physical bank and offset, so changing the mode input changes which address reaches a given byte.

Top module: `ilv_byte_mem`

## Requirements
- R1: The memory holds 16 banks of 2048 bytes behind a 15-bit byte address. A byte written to any address reads back unchanged, and writing one byte leaves its neighbours untouched.
- R2: With `lo_mode` = 0 (high-order interleaving), address bits [14:11] give the bank and bits [10:0] give the offset inside the bank.
- R3: With `lo_mode` = 1 (low-order interleaving), address bits [3:0] give the bank and bits [14:4] give the offset inside the bank.
- R4: A stored byte keeps its physical bank and offset when `lo_mode` changes, so after a change it is reached through the address that the new mapping assigns to that bank and offset.
- R5: `req_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit. Multi-byte data is little-endian: the byte at the lowest address is on bits [7:0] of `req_wdata` and `rsp_rdata`. Read-data bits above the access size are zero.
- R6: A 16-bit access with address bit 0 set, a 32-bit access with address bits [1:0] not both zero, and any access with `req_size` = 3 are errors. For an error, `rsp_err` is high in the response cycle and `rsp_rdata` is zero.
- R7: A write flagged as an error changes no byte of the memory.
- R8: `rsp_valid` is high in exactly the cycle after each clock edge that samples `req_valid` high, for reads and for writes, and it is low otherwise. Read data is valid in that same cycle. For writes and errors `rsp_rdata` is zero.
- R9: While `rst_n` is low and in the first cycle after it is released, `rsp_valid` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_mode | input | 1 | Interleave select: 1 = low-order bank bits, 0 = high-order |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 15 | Byte address (lowest byte of the access) |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Previous request was misaligned or reserved |
| rsp_rdata | output | 32 | Read data, zero-extended |

## Verification
The bench keeps a reference image of the memory indexed by physical bank and offset. It switches the interleave mode between accesses without rewriting. A design that routed the wrong address field to the bank select, or that let a mode change disturb stored data, would then return bytes from the wrong location. Misaligned and reserved-size writes are followed by aligned reads of the same bytes, which exposes a design that writes part of a bad access. Accesses at the last word of the address space and byte and halfword reads check the byte lane ordering and the zeroed upper bits, which a swapped or unmasked lane would get wrong.

// File: rtl/ilm_pkg.sv
package ilm_pkg;

    // Access size encoding on the request interface
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Widest access in bytes and the matching column-select width
    localparam int LANES     = 4;
    localparam int LANE_BITS = 2;

endpackage

// File: rtl/ilm_req_check.sv
module ilm_req_check
    import ilm_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    output logic             err,
    output logic [LANES-1:0] lane_on
);

    always_comb begin
        err     = 1'b0;
        lane_on = '0;
        unique case (size_e'(size))
            SZ_BYTE: lane_on = 4'b0001;
            SZ_HALF: begin
                lane_on = 4'b0011;
                err     = addr_lo[0];
            end
            SZ_WORD: begin
                lane_on = 4'b1111;
                err     = |addr_lo;
            end
            default: err = 1'b1;
        endcase
        if (err) begin
            lane_on = '0;
        end
    end

endmodule

// File: rtl/ilm_addr_map.sv
module ilm_addr_map #(
    parameter int BANK_BITS = 4,
    parameter int OFF_BITS  = 11,
    localparam int ADDR_W   = BANK_BITS + OFF_BITS
) (
    input  logic                 lo_mode,
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [OFF_BITS-1:0]  off
);

    always_comb begin
        if (lo_mode) begin
            bank = addr[BANK_BITS-1:0];
            off  = addr[ADDR_W-1:BANK_BITS];
        end else begin
            bank = addr[ADDR_W-1 -: BANK_BITS];
            off  = addr[OFF_BITS-1:0];
        end
    end

endmodule

// File: rtl/ilm_bank.sv
module ilm_bank #(
    parameter int ROW_BITS = 9,
    parameter int COLS     = 4,
    localparam int DEPTH   = 1 << ROW_BITS
) (
    input  logic                               clk,
    input  logic [COLS-1:0]                    we,
    input  logic [COLS-1:0]                    re,
    input  logic [COLS-1:0][ROW_BITS-1:0]      row,
    input  logic [COLS-1:0][7:0]               wd,
    output logic [COLS-1:0][7:0]               rd
);

    // One byte column per low offset value; a bank is COLS * DEPTH bytes
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [7:0] cells [DEPTH];
        logic [7:0] col_q;

        always_ff @(posedge clk) begin
            if (we[c]) begin
                cells[row[c]] <= wd[c];
            end
            if (re[c]) begin
                col_q <= cells[row[c]];
            end
        end

        assign rd[c] = col_q;
    end

    // A column is never asked to read and write in the same cycle (R8)
    p_no_rw_clash_r8: assert property (@(posedge clk) !(|(we & re)));

endmodule

// File: rtl/ilv_byte_mem.sv
module ilv_byte_mem
    import ilm_pkg::*;
#(
    parameter int BANK_BITS = 4,
    parameter int OFF_BITS  = 11,
    localparam int ADDR_W   = BANK_BITS + OFF_BITS,
    localparam int NBANK    = 1 << BANK_BITS,
    localparam int ROW_BITS = OFF_BITS - LANE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);

    typedef struct packed {
        logic                                  vld;
        logic                                  err;
        logic                                  rd;
        logic [LANES-1:0]                      lane_on;
        logic [LANES-1:0][BANK_BITS-1:0]       lbank;
        logic [LANES-1:0][LANE_BITS-1:0]       lcol;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                                  acc_err;
    logic [LANES-1:0]                      lane_mask;
    logic [LANES-1:0][ADDR_W-1:0]          lane_addr;
    logic [LANES-1:0][BANK_BITS-1:0]       lane_bank;
    logic [LANES-1:0][OFF_BITS-1:0]        lane_off;

    logic [NBANK-1:0][LANES-1:0]           bank_we;
    logic [NBANK-1:0][LANES-1:0]           bank_re;
    logic [NBANK-1:0][LANES-1:0][ROW_BITS-1:0] bank_row;
    logic [NBANK-1:0][LANES-1:0][7:0]      bank_wd;
    logic [NBANK-1:0][LANES-1:0][7:0]      bank_rd;

    // Size and alignment check
    ilm_req_check u_chk (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .err     (acc_err),
        .lane_on (lane_mask)
    );

    // Per byte lane: address of that byte and its bank / offset
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = req_addr + ADDR_W'(k);

        ilm_addr_map #(
            .BANK_BITS (BANK_BITS),
            .OFF_BITS  (OFF_BITS)
        ) u_map (
            .lo_mode (lo_mode),
            .addr    (lane_addr[k]),
            .bank    (lane_bank[k]),
            .off     (lane_off[k])
        );
    end

    // Route active lanes to the bank column that owns each byte
    always_comb begin
        bank_we  = '0;
        bank_re  = '0;
        bank_row = '0;
        bank_wd  = '0;
        for (int j = 0; j < NBANK; j++) begin
            for (int c = 0; c < LANES; c++) begin
                for (int k = 0; k < LANES; k++) begin
                    if (req_valid && lane_mask[k]
                        && lane_bank[k] == BANK_BITS'(j)
                        && lane_off[k][LANE_BITS-1:0] == LANE_BITS'(c)) begin
                        bank_row[j][c] = lane_off[k][OFF_BITS-1:LANE_BITS];
                        bank_wd[j][c]  = req_wdata[8*k +: 8];
                        if (req_write) begin
                            bank_we[j][c] = 1'b1;
                        end else begin
                            bank_re[j][c] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    for (genvar j = 0; j < NBANK; j++) begin : g_bank
        ilm_bank #(
            .ROW_BITS (ROW_BITS),
            .COLS     (LANES)
        ) u_bank (
            .clk (clk),
            .we  (bank_we[j]),
            .re  (bank_re[j]),
            .row (bank_row[j]),
            .wd  (bank_wd[j]),
            .rd  (bank_rd[j])
        );

        // Low-order mode spreads an aligned access over banks, one column each (R3)
        p_lo_one_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lo_mode |-> $onehot0(bank_we[j] | bank_re[j]));
    end

    // Response state: next value
    always_comb begin
        rsp_d         = rsp_q;
        rsp_d.vld     = req_valid;
        rsp_d.err     = req_valid & acc_err;
        rsp_d.rd      = req_valid & ~req_write & ~acc_err;
        rsp_d.lane_on = lane_mask;
        for (int k = 0; k < LANES; k++) begin
            rsp_d.lbank[k] = lane_bank[k];
            rsp_d.lcol[k]  = lane_off[k][LANE_BITS-1:0];
        end
    end

    // Response state: register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // Gather bytes back into little-endian lane order
    always_comb begin
        rsp_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (rsp_q.rd && rsp_q.lane_on[k]) begin
                rsp_rdata[8*k +: 8] = bank_rd[rsp_q.lbank[k]][rsp_q.lcol[k]];
            end
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_err   = rsp_q.err;

    p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_word_misalign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> rsp_err);

    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    p_bad_write_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size == 2'd3
                       || (req_size == 2'd1 && req_addr[0])
                       || (req_size == 2'd2 && req_addr[1:0] != 2'b00)))
        |-> (bank_we == '0));

    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_q.lane_on[1]) |-> (rsp_rdata[31:8] == 24'd0));

endmodule

// File: tb/test_ilv_byte_mem.sv
`timescale 1ns/1ps
module test_ilv_byte_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [14:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit [7:0] model [32768];
    bit       known [32768];

    always #2 clk = ~clk;

    ilv_byte_mem i_ilv_byte_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_mode   (lo_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    // Physical index = bank * 2048 + offset (R2, R3)
    function automatic int phys(input logic [14:0] a, input bit lo);
        if (lo) return int'(a[3:0]) * 2048 + int'(a[14:4]);
        return int'(a[14:11]) * 2048 + int'(a[10:0]);
    endfunction

    function automatic bit exp_err(input logic [1:0] sz, input logic [14:0] a);
        return (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One request, checked in the response cycle against the model
    task automatic access(input bit w, input logic [1:0] sz, input logic [14:0] a,
                          input logic [31:0] wd, input bit lo, input string tag);
        bit          e;
        logic [31:0] expv, mask;
        @(negedge clk);
        lo_mode   = lo;
        req_valid = 1'b1;
        req_write = w;
        req_size  = sz;
        req_addr  = a;
        req_wdata = wd;
        e    = exp_err(sz, a);
        expv = '0;
        mask = '1;
        if (!e && !w) begin
            for (int k = 0; k < nbytes(sz); k++) begin
                int p;
                p = phys(a + 15'(k), lo);
                expv[8*k +: 8] = model[p];
                if (!known[p]) mask[8*k +: 8] = 8'h00;
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b1, {tag, " R8 rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_err == e, {tag, " R6 rsp_err"}, 32'(rsp_err), 32'(e));
        chk((rsp_rdata & mask) == (expv & mask), {tag, " R5 rsp_rdata"},
            rsp_rdata & mask, expv & mask);
        if (w && !e) begin
            for (int k = 0; k < nbytes(sz); k++) begin
                int p;
                p = phys(a + 15'(k), lo);
                model[p] = wd[8*k +: 8];
                known[p] = 1'b1;
            end
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 idle rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(rsp_err == 1'b0, "R9 reset rsp_err", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R9 after release",
            {30'd0, rsp_valid, rsp_err}, 32'd0);

        // R1 R5: word write, byte and halfword reads in high-order mode
        access(1, 2'd2, 15'h0004, 32'hA1B2C3D4, 0, "R1 word wr");
        access(0, 2'd0, 15'h0005, 0, 0, "R5 byte rd");
        access(0, 2'd1, 15'h0006, 0, 0, "R5 half rd");
        access(1, 2'd0, 15'h0006, 32'h0000_005A, 0, "R1 byte wr");
        access(0, 2'd2, 15'h0004, 0, 0, "R1 neighbours kept");

        // R6 R7: misaligned and reserved writes change nothing
        access(1, 2'd1, 15'h0005, 32'hFFFF_FFFF, 0, "R7 odd half wr");
        access(1, 2'd2, 15'h0006, 32'hFFFF_FFFF, 0, "R7 misaligned word wr");
        access(1, 2'd3, 15'h0004, 32'hFFFF_FFFF, 0, "R7 reserved size wr");
        access(0, 2'd2, 15'h0004, 0, 0, "R7 data unchanged");
        access(0, 2'd2, 15'h0001, 0, 1, "R6 misaligned word rd");
        idle_check();

        // R2 R3 R4: same physical byte through both mappings
        access(1, 2'd0, 15'h0800, 32'h0000_0077, 0, "R2 hi bank1 off0");
        access(0, 2'd0, 15'h0001, 0, 1, "R4 lo bank1 off0");
        access(1, 2'd2, 15'h0010, 32'h1122_3344, 1, "R3 lo word");
        access(0, 2'd0, 15'h0001, 0, 0, "R4 hi bank0 off1");
        access(0, 2'd0, 15'h1001, 0, 0, "R4 hi bank2 off1");

        // Boundary: last word of the space in both modes
        access(1, 2'd2, 15'h7FFC, 32'hCAFE_F00D, 0, "R2 top word hi");
        access(0, 2'd1, 15'h7FFE, 0, 0, "R5 top half hi");
        access(1, 2'd2, 15'h7FFC, 32'h0BAD_BEEF, 1, "R3 top word lo");
        access(0, 2'd2, 15'h7FFC, 0, 1, "R3 top word lo rd");
        access(0, 2'd2, 15'h7FFC, 0, 0, "R4 top word hi rd");
        idle_check();

        // Random mix over a small address pool
        for (int i = 0; i < 4000; i++) begin
            logic [14:0] a;
            logic [1:0]  sz;
            a  = 15'($urandom) & 15'h780F;
            sz = 2'($urandom % 4);
            if (($urandom % 4) != 0) begin
                a  = (sz == 2'd2) ? {a[14:2], 2'b00} : (sz == 2'd1) ? {a[14:1], 1'b0} : a;
                if (sz == 2'd3) sz = 2'd2;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            access(1'($urandom % 2), sz, a, $urandom, 1'($urandom % 2), "R1 random");
            if ((i % 500) == 0) idle_check();
        end

        req_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule